// File: doc/BRIEF.md
# DSP Address Generation Unit

The unit holds a bank of address pointers and hands out one effective address per cycle. It moves the selected pointer on its own adder, so the arithmetic datapath stays free for multiply-accumulate work. The update rules are:

- pre-modify and post-modify by an unsigned step, in either direction;
- plain offset reads, which leave the pointer unchanged;
- circular addressing inside a power-of-two buffer aligned to its own size;
- reverse-carry stepping, which walks a radix-2 FFT buffer in bit-reversed order.

The caller supplies, each cycle:

- a request strobe;
- the mode;
- the pointer index;
- the step or offset;
- a choice between two buffer lengths, each given as a log2 value.

A separate port loads a pointer. The effective address is registered and appears on the cycle after the request, with a valid flag.

Top module: `dsp_agu`

## Requirements
- R1: After reset every pointer reads 0 and `ea_valid` is low. `ea_valid` is high exactly on the cycle after a cycle with `req` high, and `ea` then holds the address for that request.
- R2: Mode 1 (pre-increment) and mode 2 (pre-decrement) form the pointer plus or minus `step`, modulo 2^AW. The result is both the address and the new pointer.
- R3: Mode 3 (post-increment) and mode 4 (post-decrement) output the old pointer as the address and store the pointer plus or minus `step`.
- R4: Mode 5 outputs the pointer plus `step`, and mode 6 outputs the pointer minus `step`. Neither mode changes the pointer.
- R5: Mode 7 (circular increment) outputs the old pointer. With k the selected log2 length, the stored value is base + ((index + step) mod 2^k), where index is the low k bits and base is the rest. Stepping past the last element wraps to the buffer start.
- R6: Mode 8 (circular decrement) outputs the old pointer and stores base + ((index - step) mod 2^k). Stepping below the buffer start wraps to the last element.
- R7: In modes 7, 8 and 9 the pointer bits at position k and above keep their value.
- R8: Mode 9 outputs the old pointer. It stores the pointer with `step` added inside the low k bits, the carry running from bit k-1 toward bit 0. With k = 3 and step 4, starting from index 0, the addresses read 0,4,2,6,1,5,3,7 and then 0 again.
- R9: `size_pick` = 0 selects `size0_log2` and `size_pick` = 1 selects `size1_log2`, per request. Valid values of k are 0..AW. Any of the NPTR pointers may use either size.
- R10: If `wr_en` loads the pointer that a request updates in the same cycle, the loaded value is stored. The address is still formed from the old pointer. A load to another pointer does not disturb the update.
- R11: Mode 0 and the unused codes 10 to 15 output the pointer and leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Address request this cycle |
| mode | input | 4 | Update rule code, see requirements |
| sel | input | $clog2(NPTR) | Pointer used by the request |
| step | input | SW | Unsigned step or offset |
| size_pick | input | 1 | Selects which buffer length applies |
| size0_log2 | input | $clog2(AW+1) | First buffer length, log2 |
| size1_log2 | input | $clog2(AW+1) | Second buffer length, log2 |
| wr_en | input | 1 | Pointer load strobe |
| wr_sel | input | $clog2(NPTR) | Pointer to load |
| wr_data | input | AW | Value to load |
| ea | output | AW | Registered effective address |
| ea_valid | output | 1 | `ea` holds a fresh address |

## Verification
A pointer load and a pointer update can land on the same register in one cycle. The bench provokes this in a directed post-increment with a clashing load. It also does so at random, since about one cycle in six carries a load whose index often matches the request. Each such case is judged two ways. The address returned must come from the pre-load pointer. A later mode-0 read must return the loaded value and not the stepped one, and a load to a different pointer must leave the stepped value in place.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [3:0] {
    AGU_HOLD     = 4'd0,
    AGU_PRE_INC  = 4'd1,
    AGU_PRE_DEC  = 4'd2,
    AGU_POST_INC = 4'd3,
    AGU_POST_DEC = 4'd4,
    AGU_OFS_ADD  = 4'd5,
    AGU_OFS_SUB  = 4'd6,
    AGU_CIRC_INC = 4'd7,
    AGU_CIRC_DEC = 4'd8,
    AGU_REV_STEP = 4'd9
  } agu_mode_e;
endpackage

// File: rtl/agu_rev_add.sv
// Reverse-carry add confined to the low log2_len bits of the pointer.
module agu_rev_add #(
  parameter int AW = 16,
  parameter int KW = 5
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [KW-1:0] log2_len,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] p_rev, s_rev, sum_rev, sum_fwd, low_mask, top_mask;

  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign p_rev[i]   = ptr[AW-1-i];
    assign s_rev[i]   = step[AW-1-i];
    assign sum_fwd[i] = sum_rev[AW-1-i];
  end

  // After reversal the field sits at the top; a normal add there carries
  // from field bit k-1 toward field bit 0, and overflow falls off the top.
  assign top_mask = ~({AW{1'b1}} >> log2_len);
  assign low_mask = ~({AW{1'b1}} << log2_len);
  assign sum_rev  = (p_rev & top_mask) + (s_rev & top_mask);
  assign nxt      = (ptr & ~low_mask) | (sum_fwd & low_mask);
endmodule

// File: rtl/agu_circ_step.sv
// Modulo step inside an aligned power-of-two buffer.
module agu_circ_step #(
  parameter int AW = 16,
  parameter int KW = 5
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [KW-1:0] log2_len,
  input  logic          down,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] low_mask, idx, idx_n;

  assign low_mask = ~({AW{1'b1}} << log2_len);
  assign idx      = ptr & low_mask;
  assign idx_n    = down ? (idx - step) : (idx + step);
  assign nxt      = (ptr & ~low_mask) | (idx_n & low_mask);
endmodule

// File: rtl/agu_modify.sv
// Combinational address and next-pointer selection for one request.
module agu_modify
  import agu_pkg::*;
#(
  parameter int AW = 16,
  parameter int KW = 5
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] step,
  input  logic [3:0]    mode,
  input  logic [KW-1:0] log2_len,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt,
  output logic          upd
);
  logic [AW-1:0] circ_n [2];
  logic [AW-1:0] rev_n;

  for (genvar d = 0; d < 2; d++) begin : g_circ
    agu_circ_step #(.AW(AW), .KW(KW)) i_circ (
      .ptr(ptr), .step(step), .log2_len(log2_len), .down(1'(d)), .nxt(circ_n[d])
    );
  end

  agu_rev_add #(.AW(AW), .KW(KW)) i_rev (
    .ptr(ptr), .step(step), .log2_len(log2_len), .nxt(rev_n)
  );

  always_comb begin
    addr = ptr;
    nxt  = ptr;
    upd  = 1'b0;
    case (agu_mode_e'(mode))
      AGU_PRE_INC:  begin nxt = ptr + step; addr = nxt; upd = 1'b1; end
      AGU_PRE_DEC:  begin nxt = ptr - step; addr = nxt; upd = 1'b1; end
      AGU_POST_INC: begin nxt = ptr + step; upd = 1'b1; end
      AGU_POST_DEC: begin nxt = ptr - step; upd = 1'b1; end
      AGU_OFS_ADD:  addr = ptr + step;
      AGU_OFS_SUB:  addr = ptr - step;
      AGU_CIRC_INC: begin nxt = circ_n[0]; upd = 1'b1; end
      AGU_CIRC_DEC: begin nxt = circ_n[1]; upd = 1'b1; end
      AGU_REV_STEP: begin nxt = rev_n; upd = 1'b1; end
      default:      ;
    endcase
  end
endmodule

// File: rtl/agu_ptr_bank.sv
// Pointer registers: one load port, one update port, load has priority.
module agu_ptr_bank #(
  parameter int AW   = 16,
  parameter int NPTR = 8,
  localparam int PSW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_en,
  input  logic [PSW-1:0]     ld_sel,
  input  logic [AW-1:0]      ld_data,
  input  logic               up_en,
  input  logic [PSW-1:0]     up_sel,
  input  logic [AW-1:0]      up_data,
  input  logic [PSW-1:0]     rd_sel,
  output logic [AW-1:0]      rd_data,
  output logic [NPTR*AW-1:0] flat
);
  logic [AW-1:0] regs [NPTR];

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)                                  regs[i] <= '0;
      else if (ld_en && ld_sel == PSW'(i))      regs[i] <= ld_data;
      else if (up_en && up_sel == PSW'(i))      regs[i] <= up_data;
    end
    assign flat[i*AW +: AW] = regs[i];
  end

  assign rd_data = regs[rd_sel];
endmodule

// File: rtl/dsp_agu.sv
module dsp_agu #(
  parameter int AW   = 16,
  parameter int NPTR = 8,
  parameter int SW   = 16,
  localparam int PSW = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int KW  = $clog2(AW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic [3:0]     mode,
  input  logic [PSW-1:0] sel,
  input  logic [SW-1:0]  step,
  input  logic           size_pick,
  input  logic [KW-1:0]  size0_log2,
  input  logic [KW-1:0]  size1_log2,
  input  logic           wr_en,
  input  logic [PSW-1:0] wr_sel,
  input  logic [AW-1:0]  wr_data,
  output logic [AW-1:0]  ea,
  output logic           ea_valid
);
  logic [AW-1:0]      cur_ptr, addr_c, nxt_c, step_w;
  logic               upd_c;
  logic [KW-1:0]      log2_len;
  logic [NPTR*AW-1:0] ptr_flat;

  assign step_w   = AW'(step);
  assign log2_len = size_pick ? size1_log2 : size0_log2;

  agu_ptr_bank #(.AW(AW), .NPTR(NPTR)) i_bank (
    .clk(clk), .rst(rst),
    .ld_en(wr_en), .ld_sel(wr_sel), .ld_data(wr_data),
    .up_en(req && upd_c), .up_sel(sel), .up_data(nxt_c),
    .rd_sel(sel), .rd_data(cur_ptr), .flat(ptr_flat)
  );

  agu_modify #(.AW(AW), .KW(KW)) i_modify (
    .ptr(cur_ptr), .step(step_w), .mode(mode), .log2_len(log2_len),
    .addr(addr_c), .nxt(nxt_c), .upd(upd_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= req;
      if (req) ea <= addr_c;
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW   = 16,
  parameter int NPTR = 8,
  parameter int PSW  = 3,
  parameter int KW   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               req,
  input logic [3:0]         mode,
  input logic [PSW-1:0]     sel,
  input logic               size_pick,
  input logic [KW-1:0]      size0_log2,
  input logic [KW-1:0]      size1_log2,
  input logic               wr_en,
  input logic [PSW-1:0]     wr_sel,
  input logic [AW-1:0]      wr_data,
  input logic [NPTR*AW-1:0] ptr_flat,
  input logic [AW-1:0]      ea,
  input logic               ea_valid
);
  logic [AW-1:0]  cur_ptr, old_q, wr_data_q, hmask_q, now_sel, now_wsel;
  logic [PSW-1:0] sel_q, wr_sel_q;
  logic           req_q, wr_en_q, clash_q, post_q, keep_q, field_q;
  logic           is_post, is_keep, is_field;
  logic [KW-1:0]  k_now;

  assign cur_ptr  = ptr_flat[sel*AW +: AW];
  assign now_sel  = ptr_flat[sel_q*AW +: AW];
  assign now_wsel = ptr_flat[wr_sel_q*AW +: AW];
  assign k_now    = size_pick ? size1_log2 : size0_log2;
  assign is_post  = (mode == 4'd3) || (mode == 4'd4) || (mode == 4'd7) ||
                    (mode == 4'd8) || (mode == 4'd9);
  assign is_field = (mode == 4'd7) || (mode == 4'd8) || (mode == 4'd9);
  assign is_keep  = (mode == 4'd0) || (mode == 4'd5) || (mode == 4'd6) || (mode > 4'd9);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0; wr_en_q <= 1'b0; clash_q <= 1'b0;
      post_q <= 1'b0; keep_q <= 1'b0; field_q <= 1'b0;
      old_q <= '0; wr_data_q <= '0; hmask_q <= '0; sel_q <= '0; wr_sel_q <= '0;
    end else begin
      req_q     <= req;
      wr_en_q   <= wr_en;
      clash_q   <= wr_en && (wr_sel == sel);
      post_q    <= is_post;
      keep_q    <= is_keep;
      field_q   <= is_field;
      old_q     <= cur_ptr;
      wr_data_q <= wr_data;
      hmask_q   <= {AW{1'b1}} << k_now;
      sel_q     <= sel;
      wr_sel_q  <= wr_sel;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> !ea_valid); // R1
  AST_VALID_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
    ea_valid == req_q); // R1
  AST_POST_USES_OLD: assert property (@(posedge clk) disable iff (rst)
    (req_q && post_q) |-> (ea == old_q)); // R3
  AST_OFFSET_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (req_q && keep_q && !clash_q) |-> (now_sel == old_q)); // R4
  AST_FIELD_HIGH_HELD: assert property (@(posedge clk) disable iff (rst)
    (req_q && field_q && !clash_q) |-> ((now_sel & hmask_q) == (old_q & hmask_q))); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |-> (now_wsel == wr_data_q)); // R10
endmodule

bind dsp_agu agu_chk #(.AW(AW), .NPTR(NPTR), .PSW(PSW), .KW(KW)) i_agu_chk (
  .clk(clk), .rst(rst), .req(req), .mode(mode), .sel(sel),
  .size_pick(size_pick), .size0_log2(size0_log2), .size1_log2(size1_log2),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .ptr_flat(ptr_flat), .ea(ea), .ea_valid(ea_valid)
);

// File: tb/test_dsp_agu.sv
module test_dsp_agu;
  localparam int AW   = 16;
  localparam int NPTR = 8;
  localparam int SW   = 16;
  localparam int PSW  = $clog2(NPTR);
  localparam int KW   = $clog2(AW + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req = 1'b0;
  logic [3:0]     mode = '0;
  logic [PSW-1:0] sel = '0;
  logic [SW-1:0]  step = '0;
  logic           size_pick = 1'b0;
  logic [KW-1:0]  size0_log2 = '0;
  logic [KW-1:0]  size1_log2 = '0;
  logic           wr_en = 1'b0;
  logic [PSW-1:0] wr_sel = '0;
  logic [AW-1:0]  wr_data = '0;
  logic [AW-1:0]  ea;
  logic           ea_valid;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] refp [NPTR];

  always #2.5 clk = ~clk;

  dsp_agu #(.AW(AW), .NPTR(NPTR), .SW(SW)) i_dsp_agu (
    .clk(clk), .rst(rst), .req(req), .mode(mode), .sel(sel), .step(step),
    .size_pick(size_pick), .size0_log2(size0_log2), .size1_log2(size1_log2),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ea(ea), .ea_valid(ea_valid)
  );

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [3:0] m);
    case (m)
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5, 4'd6: return "R4";
      4'd7:       return "R5";
      4'd8:       return "R6";
      4'd9:       return "R8";
      default:    return "R11";
    endcase
  endfunction

  // Circular step computed with integer modulo arithmetic
  function automatic logic [AW-1:0] ref_circ(input logic [AW-1:0] p, input logic [AW-1:0] s,
                                             input int k, input bit down);
    longint len, idx, base, st, r;
    len  = longint'(1) << k;
    idx  = longint'(p) % len;
    base = longint'(p) - idx;
    st   = longint'(s) % len;
    r    = down ? base + ((idx + len - st) % len) : base + ((idx + st) % len);
    return AW'(r);
  endfunction

  // Bitwise reverse-carry add, carry moves from bit k-1 down to bit 0
  function automatic logic [AW-1:0] ref_rev(input logic [AW-1:0] p, input logic [AW-1:0] s,
                                            input int k);
    logic [AW-1:0] r = p;
    int c = 0;
    for (int i = k - 1; i >= 0; i--) begin
      int t = int'(p[i]) + int'(s[i]) + c;
      r[i] = t[0];
      c = t / 2;
    end
    return r;
  endfunction

  // One request cycle; inputs are driven at a negedge, results sampled at the next.
  task automatic op(input bit r, input logic [3:0] m, input int s, input logic [SW-1:0] st,
                    input bit pk, input bit w, input int ws, input logic [AW-1:0] wd,
                    input string tag);
    logic [AW-1:0] old, exp_ea, nxt, stw;
    bit upd = 0;
    int k;
    string t;
    t = (tag == "") ? mode_tag(m) : tag;
    req = r; mode = m; sel = PSW'(s); step = st; size_pick = pk;
    wr_en = w; wr_sel = PSW'(ws); wr_data = wd;
    k   = pk ? int'(size1_log2) : int'(size0_log2);
    stw = AW'(st);
    old = refp[s];
    exp_ea = old;
    nxt = old;
    case (m)
      4'd1: begin nxt = old + stw; exp_ea = nxt; upd = 1; end
      4'd2: begin nxt = old - stw; exp_ea = nxt; upd = 1; end
      4'd3: begin nxt = old + stw; upd = 1; end
      4'd4: begin nxt = old - stw; upd = 1; end
      4'd5: exp_ea = old + stw;
      4'd6: exp_ea = old - stw;
      4'd7: begin nxt = ref_circ(old, stw, k, 0); upd = 1; end
      4'd8: begin nxt = ref_circ(old, stw, k, 1); upd = 1; end
      4'd9: begin nxt = ref_rev(old, stw, k); upd = 1; end
      default: ;
    endcase
    if (r && upd) refp[s] = nxt;
    if (w) refp[ws] = wd;
    @(negedge clk);
    chk({t, " valid"}, AW'(ea_valid), AW'(r));
    if (r) chk(t, ea, exp_ea);
    req = 0; wr_en = 0;
  endtask

  task automatic rd(input int s, input string tag);
    op(1, 4'd0, s, '0, 0, 0, 0, '0, tag);
  endtask

  task automatic load(input int s, input logic [AW-1:0] d);
    op(0, 4'd0, 0, '0, 0, 1, s, d, "R1");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPTR; i++) refp[i] = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1 valid after reset", AW'(ea_valid), '0);
    for (int i = 0; i < NPTR; i++) rd(i, "R1");

    // R8: 8-point bit-reversed walk, high bits held (R7)
    size0_log2 = 3;
    load(2, 16'h1230);
    for (int i = 0; i < 9; i++) op(1, 4'd9, 2, 16'd4, 0, 0, 0, '0, "R8");
    rd(2, "R7");

    // R5 / R6: circular wrap at both ends, buffer of 4
    size1_log2 = 2;
    load(5, 16'h00F6);
    for (int i = 0; i < 4; i++) op(1, 4'd7, 5, 16'd1, 1, 0, 0, '0, "R5");
    load(5, 16'h00F4);
    op(1, 4'd8, 5, 16'd1, 1, 0, 0, '0, "R6");
    rd(5, "R6");

    // R7: field edge cases with k = 4
    size1_log2 = 4;
    load(6, 16'hABCF);
    op(1, 4'd7, 6, 16'd3, 1, 0, 0, '0, "R7");
    rd(6, "R7");
    op(1, 4'd9, 6, 16'd8, 1, 0, 0, '0, "R7");
    rd(6, "R7");

    // R2 / R3: pre and post modify, with wrap at 2^AW
    load(0, 16'hFFFE);
    op(1, 4'd1, 0, 16'd3, 0, 0, 0, '0, "R2");
    op(1, 4'd2, 0, 16'd5, 0, 0, 0, '0, "R2");
    op(1, 4'd3, 0, 16'd7, 0, 0, 0, '0, "R3");
    op(1, 4'd4, 0, 16'd2, 0, 0, 0, '0, "R3");
    rd(0, "R3");

    // R4: offsets leave the pointer unchanged
    load(4, 16'h0100);
    op(1, 4'd5, 4, 16'h0020, 0, 0, 0, '0, "R4");
    op(1, 4'd6, 4, 16'h0200, 0, 0, 0, '0, "R4");
    rd(4, "R4");

    // R10: load and update on the same pointer, then on different pointers
    load(1, 16'h0010);
    op(1, 4'd3, 1, 16'd1, 0, 1, 1, 16'h5555, "R10");
    rd(1, "R10");
    op(1, 4'd3, 1, 16'd1, 0, 1, 3, 16'h7777, "R10");
    rd(1, "R10");
    rd(3, "R10");

    // R9: two sizes used alternately on two pointers
    size0_log2 = 3; size1_log2 = 5;
    load(7, 16'h0047);
    load(3, 16'h005F);
    op(1, 4'd7, 7, 16'd2, 0, 0, 0, '0, "R9");
    op(1, 4'd7, 3, 16'd2, 1, 0, 0, '0, "R9");
    rd(7, "R9");
    rd(3, "R9");

    // R11: unused mode code
    op(1, 4'd12, 3, 16'd9, 0, 0, 0, '0, "R11");
    rd(3, "R11");

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [SW-1:0] st;
      if ($urandom_range(0, 15) == 0) begin
        size0_log2 = KW'($urandom_range(0, AW));
        size1_log2 = KW'($urandom_range(0, AW));
      end
      st = ($urandom_range(0, 3) == 0) ? SW'($urandom) : SW'($urandom_range(0, 9));
      op($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)), $urandom_range(0, NPTR-1),
         st, 1'($urandom_range(0, 1)), $urandom_range(0, 5) == 0,
         $urandom_range(0, NPTR-1), AW'($urandom), "");
    end
    for (int i = 0; i < NPTR; i++) rd(i, "R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule